// File: doc/BRIEF.md
# Packet Receive Word Buffer

This block sits behind a receive framer that has already removed line flags and stuffing. It takes one byte per cycle, along with start, end and abort markers. It packs the bytes four to a 32-bit word and holds those words until a host pops them.

The buffer is store-and-forward. Words of a packet become visible to the host only after the packet's final byte has arrived. If a packet is aborted on the line, or does not fit in the buffer, its words are rolled back before the host can see any of them.

The host reads a status word to plan its reads:
- a one-word ready flag;
- an eight-word block flag, for burst reads;
- a flag showing that an end of packet is somewhere in the buffer;
- a look-ahead flag saying that the next word to pop is the final word of its packet;
- a byte-count code for that final word;
- a sticky abort flag.

The host reads data through a head-of-buffer data port. Each pulse on the pop input removes one word.

Top module: `pkt_rx_wordbuf`

## Requirements
- R1: After reset every status bit is 0 and `rd_data` is 0.
- R2: Bytes are packed little-endian: the first byte of a word goes to bits 7:0 and the fourth to bits 31:24. A short final word is zero-padded. `rd_data` shows the oldest word and each `rd_pop` pulse advances to the next word.
- R3: Status bit 0 (ready) is 1 while at least one word of a completed packet is held. Words of a packet become visible in the cycle after the edge that accepts its end byte.
- R4: Status bit 6 (block) is 1 while eight or more visible words are held.
- R5: Status bit 5 (end present) is 1 while the buffer holds the final word of any packet.
- R6: Status bit 1 (next is last) is 1 when the word on `rd_data` is the final word of its packet.
- R7: Status bits 4:3 give the valid bytes of that final word as a code: 00 means one byte, 01 two, 10 three and 11 four. These bits are 00 whenever bit 1 is 0.
- R8: An abort strobe discards the partial packet in progress and sets status bit 2. A packet committed earlier is kept. Bit 2 stays 1 until a status read (`stat_rd`), and a new abort in the same cycle as that read wins.
- R9: A pop while bit 0 is 0 returns `rd_data` = 0 and changes no state.
- R10: The buffer holds 16 words. A packet whose next word finds the buffer full is dropped whole: its bytes up to the next start are ignored, and bit 2 is set. Packets already committed stay intact.
- R11: Status bits 31:7 always read 0.
- R12: A start marker arriving while a packet is still open discards the open packet's words and begins a new packet with the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is on `in_byte` this cycle |
| in_byte | input | 8 | Received byte |
| in_sop | input | 1 | This byte is the first of a packet |
| in_eop | input | 1 | This byte is the last of a packet |
| in_abort | input | 1 | Abort strobe for the packet in progress (the byte lane is ignored that cycle) |
| stat_rd | input | 1 | Host status read, clears the abort flag |
| stat_word | output | 32 | Status word |
| rd_pop | input | 1 | Host pop of the head word |
| rd_data | output | 32 | Head word, or 0 when nothing is ready |

## Verification
A wrong write or commit pointer shows up at the ports on the first pop after the faulty packet, as a shifted or stale word on `rd_data`. A packet that was aborted or dropped and is wrongly left visible raises ready one cycle after the abort. A miscounted end-of-packet tally leaves bit 5 or bit 1 wrong in the status word. The bench compares the entire status word before every pop, so such an error is caught at the very next word boundary. The bench sweeps every packet length from 1 to 20 bytes and covers the exact-fill, mid-packet overflow, abort and empty-pop cases, each against values computed from the byte pattern.

// File: rtl/pkt_rx_pkg.sv
// Package: shared types for the packet receive word buffer.
// Assumes a fixed 32-bit host word made of four bytes.
package pkt_rx_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    // One stored word with its end-of-packet mark and byte-count code.
    typedef struct packed {
        logic              last;
        logic [1:0]        len;
        logic [WORD_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/pkt_rx_packer.sv
// Module: byte-to-word packer.
// It collects bytes little-endian into a 32-bit word and requests a push
// when the word fills or the packet ends. It asks for a rollback of the
// open packet on an abort, on an overflow, or on a start arriving mid-packet.
// Assumes the store reports `full` for the speculative (uncommitted) count.
module pkt_rx_packer
    import pkt_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_abort,
    input  logic              full,
    output logic              push,
    output rx_entry_t         push_ent,
    output logic              discard,
    output logic              abort_evt
);
    logic [WORD_W-1:0] acc_q;
    logic [1:0]        cnt_q;
    logic              active_q;

    logic              take;
    logic [1:0]        pos;
    logic [WORD_W-1:0] merged;
    logic              need;
    logic              ovf;

    // Work out where the byte lands and whether a word leaves this cycle.
    always_comb begin
        take    = in_valid && !in_abort && (in_sop || active_q);
        pos     = in_sop ? 2'd0 : cnt_q;
        merged  = ((in_sop || cnt_q == 2'd0) ? '0 : acc_q)
                | ({{(WORD_W-BYTE_W){1'b0}}, in_byte} << {pos, 3'b000});
        need    = take && (pos == 2'd3 || in_eop);
        push    = need && !full;
        ovf     = need && full;
        discard = in_abort || ovf || (take && in_sop && active_q);
        abort_evt = in_abort || ovf;
        push_ent.last = in_eop;
        push_ent.len  = pos;
        push_ent.data = merged;
    end

    // Keep the partial word, the byte position and the in-packet state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (abort_evt) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (take) begin
            if (need) begin
                acc_q    <= '0;
                cnt_q    <= '0;
                active_q <= !in_eop;
            end else begin
                acc_q    <= merged;
                cnt_q    <= pos + 2'd1;
                active_q <= 1'b1;
            end
        end
    end

    // R8
    abort_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_abort |=> (!active_q && cnt_q == 2'd0));

    // R10
    ovf_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !active_q);

    // R2
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (cnt_q == 2'd0));
endmodule

// File: rtl/pkt_rx_store.sv
// Module: word store with speculative write, commit and read pointers.
// Pushed words stay hidden until the word carrying the end mark is written.
// A discard rolls the write pointer back to the last commit point.
// Assumes the packer never pushes when `full` is high.
module pkt_rx_store
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
)(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      discard,
    input  logic      pop,
    output logic      full,
    output logic [PW-1:0] avail,
    output rx_entry_t head,
    output logic      eop_pend
);
    rx_entry_t      mem [DEPTH];
    logic [PW-1:0]  wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0]  eop_cnt;
    logic [PW-1:0]  base;
    logic           do_pop;

    // Derive occupancy, head view and the effective write base.
    always_comb begin
        base     = discard ? cm_ptr : wr_ptr;
        full     = (wr_ptr - rd_ptr) == PW'(DEPTH);
        avail    = cm_ptr - rd_ptr;
        head     = mem[rd_ptr[AW-1:0]];
        eop_pend = eop_cnt != '0;
        do_pop   = pop && (avail != '0);
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (push)
            mem[base[AW-1:0]] <= push_ent;
    end

    // Move the write, commit and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= base + PW'(1);
                if (push_ent.last)
                    cm_ptr <= base + PW'(1);
            end else if (discard) begin
                wr_ptr <= cm_ptr;
            end
            if (do_pop)
                rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // Count final words present in the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eop_cnt <= '0;
        else
            eop_cnt <= eop_cnt + PW'(push && push_ent.last)
                               - PW'(do_pop && head.last);
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr) <= PW'(DEPTH));

    // R3
    commit_behind_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && avail == '0) |=> $stable(rd_ptr));

    // R5
    eop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_cnt <= avail);
endmodule

// File: rtl/pkt_rx_wordbuf.sv
// Module: top of the packet receive word buffer.
// It joins the packer and the store, holds the sticky abort flag and forms
// the host status word and the head data view.
// Assumes one byte at most per cycle from an upstream framer.
module pkt_rx_wordbuf
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int BLOCK_WORDS = 8,
    localparam int PW = $clog2(DEPTH) + 1
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic        in_abort,
    input  logic        stat_rd,
    output logic [31:0] stat_word,
    input  logic        rd_pop,
    output logic [31:0] rd_data
);
    logic          full, push, discard, abort_evt, eop_pend;
    rx_entry_t     push_ent, head;
    logic [PW-1:0] avail;
    logic          abort_q;
    logic          rdy, blk, nxt_last;

    pkt_rx_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_abort  (in_abort),
        .full      (full),
        .push      (push),
        .push_ent  (push_ent),
        .discard   (discard),
        .abort_evt (abort_evt)
    );

    pkt_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .discard  (discard),
        .pop      (rd_pop),
        .full     (full),
        .avail    (avail),
        .head     (head),
        .eop_pend (eop_pend)
    );

    // Sticky abort flag: a new event wins over the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            abort_q <= 1'b0;
        else if (abort_evt)
            abort_q <= 1'b1;
        else if (stat_rd)
            abort_q <= 1'b0;
    end

    // Assemble the status word and the head data view.
    always_comb begin
        rdy       = avail != '0;
        blk       = avail >= PW'(BLOCK_WORDS);
        nxt_last  = rdy && head.last;
        stat_word = {25'b0, blk, eop_pend,
                     nxt_last ? head.len : 2'b00,
                     abort_q, nxt_last, rdy};
        rd_data   = rdy ? head.data : '0;
    end

    // R4
    blk_implies_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[6] |-> stat_word[0]);

    // R6
    nxt_implies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[1] |-> stat_word[5]);

    // R8
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[2] && !stat_rd) |=> stat_word[2]);

    // R8
    abort_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_abort |=> stat_word[2]);

    // R9
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[0] |-> rd_data == 32'h0);
endmodule

// File: tb/pkt_rx_wordbuf_tb.sv
module pkt_rx_wordbuf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_abort = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        stat_rd = 1'b0, rd_pop = 1'b0;
    logic [31:0] stat_word, rd_data;
    int          nvec = 0, nerr = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_rx_wordbuf u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_sop(in_sop), .in_eop(in_eop), .in_abort(in_abort),
        .stat_rd(stat_rd), .stat_word(stat_word),
        .rd_pop(rd_pop), .rd_data(rd_data)
    );

    function automatic logic [7:0] pb(int p, int i);
        return 8'((p * 37 + i * 11 + 1) & 255);
    endfunction

    function automatic logic [31:0] ew(int p, int len, int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++)
            if (4 * k + j < len) w = w | (32'(pb(p, 4 * k + j)) << (8 * j));
        return w;
    endfunction

    function automatic logic [31:0] es(bit blk, bit endp, logic [1:0] len,
                                       bit ab, bit nxt, bit rdy);
        return {25'b0, blk, endp, len, ab, nxt, rdy};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Send bytes [0, stop) of packet p of total length len; eop only if stop==len.
    task automatic send(int p, int len, int stop);
        for (int i = 0; i < stop; i++) begin
            in_valid = 1'b1; in_byte = pb(p, i);
            in_sop = (i == 0); in_eop = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
    endtask

    task automatic abort_beat();
        in_abort = 1'b1; @(negedge clk); in_abort = 1'b0; @(negedge clk);
    endtask

    task automatic read_stat(output logic [31:0] s);
        s = stat_word; stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pop(output logic [31:0] d);
        d = rd_data; rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    endtask

    // Drain packet p (len bytes) at the head; `rest` words follow it.
    task automatic drain(int p, int len, int rest, string req);
        int w = (len + 3) / 4;
        logic [31:0] d;
        for (int k = 0; k < w; k++) begin
            bit nxt = (k == w - 1);
            logic [1:0] lc = nxt ? 2'((len - 1) % 4) : 2'b00;
            check({req, " R3 R4 R5 R6 R7 R11 status"}, stat_word,
                  es((w - k + rest) >= 8, 1'b1, lc, 1'b0, nxt, 1'b1));
            pop(d);
            check({req, " R2 data"}, d, ew(p, len, k));
        end
    endtask

    initial begin
        logic [31:0] s, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", stat_word, 32'h0);
        check("R1 data", rd_data, 32'h0);

        // R9 pop on empty returns zero and moves nothing
        pop(d);
        check("R9 data", d, 32'h0);
        check("R9 status", stat_word, 32'h0);
        send(1, 6, 6);
        drain(1, 6, 0, "R9 after empty pop");

        // R2 R3 R6 R7 sweep of all lengths 1..20
        for (int len = 1; len <= 20; len++) begin
            send(100 + len, len, len);
            drain(100 + len, len, 0, "sweep");
            check("R3 R5 empty after drain", stat_word, 32'h0);
        end

        // R5 R6 two packets queued
        send(2, 5, 5);
        send(3, 3, 3);
        drain(2, 5, 1, "R5 two packets");
        drain(3, 3, 0, "R5 second packet");
        check("R5 end cleared", stat_word, 32'h0);

        // R4 block boundary: 8 words then 7
        send(4, 32, 32);
        drain(4, 32, 0, "R4 block");

        // R8 abort with committed packet kept
        send(5, 3, 3);
        send(6, 20, 9);
        abort_beat();
        check("R8 abort status", stat_word, es(0, 1, 2'b10, 1, 1, 1));
        read_stat(s);
        check("R8 status read value", s, es(0, 1, 2'b10, 1, 1, 1));
        check("R8 abort cleared", stat_word, es(0, 1, 2'b10, 0, 1, 1));
        drain(5, 3, 0, "R8 kept packet");
        check("R8 no partial words", stat_word, 32'h0);

        // R8 abort coinciding with a status read: abort wins
        in_abort = 1'b1; stat_rd = 1'b1; @(negedge clk);
        in_abort = 1'b0; stat_rd = 1'b0; @(negedge clk);
        check("R8 abort wins over read", stat_word, es(0, 0, 2'b00, 1, 0, 0));
        read_stat(s);
        check("R8 cleared", stat_word, 32'h0);

        // R10 exact fill, then a one-byte packet is dropped
        send(7, 64, 64);
        check("R10 full visible", stat_word, es(1, 1, 0, 0, 0, 1));
        send(8, 1, 1);
        check("R10 drop flags abort", stat_word, es(1, 1, 0, 1, 0, 1));
        read_stat(s);
        drain(7, 64, 0, "R10 exact fill");
        check("R10 empty", stat_word, 32'h0);

        // R10 overflow in the middle of a packet, earlier one intact
        send(9, 48, 48);
        send(10, 32, 32);
        check("R10 mid drop", stat_word, es(1, 1, 0, 1, 0, 1));
        read_stat(s);
        drain(9, 48, 0, "R10 intact");
        check("R10 dropped tail ignored", stat_word, 32'h0);

        // R12 restart mid-packet discards the open packet
        send(11, 20, 7);
        send(12, 5, 5);
        check("R12 no abort flag", stat_word[2], 32'h0);
        drain(12, 5, 0, "R12 restart");
        check("R12 empty", stat_word, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule